// File: doc/BRIEF.md
# Bank-Switching Memory Mapper

This block lets a 24-bit processor without a memory management unit run overlaid code from a small on-chip SRAM. The processor address carries an 8-bit bank number above a 16-bit offset. The 256 banks fall into eight fixed groups, and each group shares one physical region of SRAM. A register per group names the one bank of that group that is resident at the moment. Each fetch or load is looked up combinationally. If the bank is the one loaded for its group, the block forms an SRAM address from the group's base and the offset, cut down to the group's page size, and passes the SRAM data through.

If the bank is not loaded, the block puts a fixed undefined instruction word on the read data bus, so the processor takes its unknown-instruction trap. It also records the bank that missed in a sticky status register. The trap handler copies the bank into SRAM, writes the bank register and returns, and the retried access then hits. Bank 0 is the resident area and always maps straight onto a fixed SRAM window.

Top module: `bank_mapper`

## Requirements
- R1: The bank number is `cpu_addr[23:16]` and the offset is `cpu_addr[15:0]`. The bank's group is bank bits 7:5, and only that group's register decides whether a banked access hits.
- R2: A request (`cpu_req`=1) to bank B of group G, with B not 0, hits when G's bank register equals B and B is not 0xFF. A hit drives `sram_en`=1, `cpu_miss`=0, `sram_addr` = (base of G + (offset AND page mask)) mod 2^16, and `cpu_rdata` = `sram_rdata`.
- R3: Size code 0, 1, 2 or 3 selects a page of 1, 2, 4 or 8 KB. The page mask is (1024 << code) - 1, so offset bits at or above the page size have no effect on `sram_addr`.
- R4: A request to a banked address that does not hit drives `cpu_miss`=1, `sram_en`=0 and `cpu_rdata`=32'h0BAD_F00D. With no request, `cpu_miss` and `sram_en` are both 0.
- R5: A request to bank 0 always hits and never misses. Its address is `sram_addr` = 16'hE000 + `cpu_addr[12:0]`, whatever the group 0 register holds.
- R6: After reset every bank register holds 0xFF and the status is clear, so every banked access misses. A bank number of 0xFF never hits, even after 0xFF is written to a register.
- R7: A pulse on `bank_we` writes `cfg_bank` into the register of group `cfg_grp`. An access in the same cycle still sees the old value, and the access in the next cycle sees the new one.
- R8: A missing request sets `sts_miss` from the next cycle on, and loads `sts_bank` and `sts_grp` with the bank and group of the miss. These fields hold until the next miss.
- R9: `sts_rd`=1 clears `sts_miss` in the next cycle. If a miss happens in the same cycle, the miss wins: the flag stays set and the fields take the new miss.
- R10: A pulse on `region_we` writes `cfg_base` and `cfg_size` for group `cfg_grp`, and the new values apply from the next cycle on. `region_we` and `bank_we` are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access valid |
| cpu_addr | input | 24 | Processor virtual address |
| cpu_rdata | output | 32 | Read data to the processor (trap word on a miss) |
| cpu_miss | output | 1 | Current request missed |
| sram_en | output | 1 | SRAM access enable |
| sram_addr | output | 16 | SRAM byte address |
| sram_rdata | input | 32 | SRAM read data |
| bank_we | input | 1 | Write a bank register |
| region_we | input | 1 | Write a group's base and size |
| cfg_grp | input | 3 | Group chosen for a write |
| cfg_bank | input | 8 | Bank number to write |
| cfg_base | input | 16 | SRAM base of the group |
| cfg_size | input | 2 | Page size code |
| sts_rd | input | 1 | Read-and-clear strobe for the miss flag |
| sts_miss | output | 1 | Sticky miss flag |
| sts_bank | output | 8 | Bank of the last miss |
| sts_grp | output | 3 | Group of the last miss |

## Verification
Directed accesses first run against the reset state and then against bank 0, bank 0xFF and a bank placed in the wrong group's register. These separate the resident bypass, the reserved value and the group decode. Offsets at and above 1 KB and 8 KB pages show whether the page mask is applied, and writes timed in the same cycle as the access show whether register updates take effect one cycle later. A long random run then mixes a small set of bank numbers with register writes and status reads, so that hit, miss, clear and write collisions occur together. A behavioural model tracks every cycle of it.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int unsigned CPU_AW   = 24;
  localparam int unsigned BANK_W   = 8;
  localparam int unsigned GRP_W    = 3;
  localparam int unsigned NGRP     = 1 << GRP_W;
  localparam int unsigned OFF_W    = CPU_AW - BANK_W;
  localparam int unsigned PA_W     = 16;
  localparam int unsigned DW       = 32;
  localparam int unsigned SZ_W     = 2;
  localparam int unsigned MIN_PG_W = 10;
  localparam int unsigned RES_AW   = 13;

  localparam logic [BANK_W-1:0] BANK_NONE = '1;
  localparam logic [BANK_W-1:0] RES_BANK  = '0;
  localparam logic [PA_W-1:0]   RES_BASE  = 16'hE000;
  localparam logic [DW-1:0]     TRAP_WORD = 32'h0BAD_F00D;

  typedef struct packed {
    logic [PA_W-1:0] base;
    logic [SZ_W-1:0] size;
  } region_t;
endpackage

// File: rtl/bmap_regfile.sv
module bmap_regfile
  import bank_mapper_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bank_we,
  input  logic                          region_we,
  input  logic [GRP_W-1:0]              cfg_grp,
  input  logic [BANK_W-1:0]             cfg_bank,
  input  logic [PA_W-1:0]               cfg_base,
  input  logic [SZ_W-1:0]               cfg_size,
  output logic [NGRP-1:0][BANK_W-1:0]   bank_q,
  output region_t [NGRP-1:0]            region_q
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic              bank_en, reg_en;
    logic [BANK_W-1:0] bank_d, bank_r;
    region_t           reg_d, reg_r;

    assign bank_en = bank_we   && (cfg_grp == GRP_W'(g));
    assign reg_en  = region_we && (cfg_grp == GRP_W'(g));

    always_comb begin
      bank_d = bank_en ? cfg_bank : bank_r;
      reg_d  = reg_en ? region_t'{base: cfg_base, size: cfg_size} : reg_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_r <= BANK_NONE;
        reg_r  <= '0;
      end else begin
        bank_r <= bank_d;
        reg_r  <= reg_d;
      end
    end

    assign bank_q[g]   = bank_r;
    assign region_q[g] = reg_r;
  end
endmodule

// File: rtl/bmap_xlate.sv
module bmap_xlate
  import bank_mapper_pkg::*;
(
  input  logic                          cpu_req,
  input  logic [CPU_AW-1:0]             cpu_addr,
  input  logic [NGRP-1:0][BANK_W-1:0]   bank_q,
  input  region_t [NGRP-1:0]            region_q,
  input  logic [DW-1:0]                 sram_rdata,
  output logic [DW-1:0]                 cpu_rdata,
  output logic                          cpu_miss,
  output logic                          sram_en,
  output logic [PA_W-1:0]               sram_addr,
  output logic [BANK_W-1:0]             acc_bank,
  output logic [GRP_W-1:0]              acc_grp
);
  logic [OFF_W-1:0]  off, page_mask;
  logic [BANK_W-1:0] sel_bank;
  region_t           sel_reg;
  logic              resident, loaded;
  logic [PA_W-1:0]   bank_addr, res_addr;

  always_comb begin
    acc_bank  = cpu_addr[CPU_AW-1 -: BANK_W];
    acc_grp   = acc_bank[BANK_W-1 -: GRP_W];
    off       = cpu_addr[OFF_W-1:0];
    resident  = (acc_bank == RES_BANK);
    sel_bank  = bank_q[acc_grp];
    sel_reg   = region_q[acc_grp];
    loaded    = (sel_bank == acc_bank) && (sel_bank != BANK_NONE);
    page_mask = (OFF_W'(1) << (MIN_PG_W + 32'(sel_reg.size))) - OFF_W'(1);
    bank_addr = sel_reg.base + PA_W'(off & page_mask);
    res_addr  = RES_BASE + PA_W'(off[RES_AW-1:0]);
    sram_en   = cpu_req && (resident || loaded);
    cpu_miss  = cpu_req && !resident && !loaded;
    sram_addr = resident ? res_addr : bank_addr;
    cpu_rdata = cpu_miss ? TRAP_WORD : sram_rdata;
  end
endmodule

// File: rtl/bmap_status.sv
module bmap_status
  import bank_mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_evt,
  input  logic [BANK_W-1:0] miss_bank,
  input  logic [GRP_W-1:0]  miss_grp,
  input  logic              sts_rd,
  output logic              sts_miss,
  output logic [BANK_W-1:0] sts_bank,
  output logic [GRP_W-1:0]  sts_grp
);
  logic              flag_d, flag_q;
  logic [BANK_W-1:0] bank_d, bank_r;
  logic [GRP_W-1:0]  grp_d, grp_r;

  always_comb begin
    flag_d = flag_q;
    bank_d = bank_r;
    grp_d  = grp_r;
    if (miss_evt) begin
      flag_d = 1'b1;
      bank_d = miss_bank;
      grp_d  = miss_grp;
    end else if (sts_rd) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      bank_r <= '0;
      grp_r  <= '0;
    end else begin
      flag_q <= flag_d;
      bank_r <= bank_d;
      grp_r  <= grp_d;
    end
  end

  assign sts_miss = flag_q;
  assign sts_bank = bank_r;
  assign sts_grp  = grp_r;
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_miss,
  output logic              sram_en,
  output logic [PA_W-1:0]   sram_addr,
  input  logic [DW-1:0]     sram_rdata,
  input  logic              bank_we,
  input  logic              region_we,
  input  logic [GRP_W-1:0]  cfg_grp,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic              sts_rd,
  output logic              sts_miss,
  output logic [BANK_W-1:0] sts_bank,
  output logic [GRP_W-1:0]  sts_grp
);
  logic [1:0] rst_pipe_d, rst_pipe_q;
  logic       rst_sync_n;

  assign rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NGRP-1:0][BANK_W-1:0] bank_q;
  region_t [NGRP-1:0]          region_q;
  logic [BANK_W-1:0]           acc_bank;
  logic [GRP_W-1:0]            acc_grp;

  bmap_regfile u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bank_we(bank_we), .region_we(region_we),
    .cfg_grp(cfg_grp), .cfg_bank(cfg_bank), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .bank_q(bank_q), .region_q(region_q)
  );

  bmap_xlate u_xlate (
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .bank_q(bank_q),
    .region_q(region_q), .sram_rdata(sram_rdata), .cpu_rdata(cpu_rdata),
    .cpu_miss(cpu_miss), .sram_en(sram_en), .sram_addr(sram_addr),
    .acc_bank(acc_bank), .acc_grp(acc_grp)
  );

  bmap_status u_sts (
    .clk(clk), .rst_n(rst_sync_n), .miss_evt(cpu_miss), .miss_bank(acc_bank),
    .miss_grp(acc_grp), .sts_rd(sts_rd), .sts_miss(sts_miss),
    .sts_bank(sts_bank), .sts_grp(sts_grp)
  );

  AST_MISS_TRAPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_miss |-> (!sram_en && cpu_rdata == TRAP_WORD)); // R4
  AST_RESIDENT_HITS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req && cpu_addr[CPU_AW-1 -: BANK_W] == RES_BANK) |-> (sram_en && !cpu_miss)); // R5
  AST_RESERVED_MISSES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req && cpu_addr[CPU_AW-1 -: BANK_W] == BANK_NONE) |-> cpu_miss); // R6
  AST_WRITE_NEXT_HITS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bank_we && cfg_bank != BANK_NONE && cfg_bank != RES_BANK &&
     cfg_bank[BANK_W-1 -: GRP_W] == cfg_grp)
    |=> !(cpu_req && cpu_miss && cpu_addr[CPU_AW-1 -: BANK_W] == $past(cfg_bank))); // R7
  AST_MISS_LATCHED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_miss |=> (sts_miss && sts_bank == $past(cpu_addr[CPU_AW-1 -: BANK_W]))); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sts_rd && !cpu_miss) |=> !sts_miss); // R9
endmodule

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req;
  logic [23:0] cpu_addr;
  logic [31:0] cpu_rdata;
  logic        cpu_miss, sram_en;
  logic [15:0] sram_addr;
  logic [31:0] sram_rdata;
  logic        bank_we, region_we, sts_rd;
  logic [2:0]  cfg_grp;
  logic [7:0]  cfg_bank;
  logic [15:0] cfg_base;
  logic [1:0]  cfg_size;
  logic        sts_miss;
  logic [7:0]  sts_bank;
  logic [2:0]  sts_grp;

  always #5 clk = ~clk;

  assign sram_rdata = {16'hC0DE, sram_addr};

  bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_rdata(cpu_rdata), .cpu_miss(cpu_miss), .sram_en(sram_en),
    .sram_addr(sram_addr), .sram_rdata(sram_rdata), .bank_we(bank_we),
    .region_we(region_we), .cfg_grp(cfg_grp), .cfg_bank(cfg_bank),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .sts_rd(sts_rd),
    .sts_miss(sts_miss), .sts_bank(sts_bank), .sts_grp(sts_grp)
  );

  int checks = 0;
  int errors = 0;
  int bank_m[8];
  int base_m[8];
  int size_m[8];
  int flag_m, sbank_m, sgrp_m;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit req, int addr, bit bwe, bit rwe, int grp,
                      int bnk, int base, int size, bit rd);
    int b, g, off, ea, en, ms;
    string t;
    @(negedge clk);
    cpu_req = req; cpu_addr = 24'(addr); bank_we = bwe; region_we = rwe;
    cfg_grp = 3'(grp); cfg_bank = 8'(bnk); cfg_base = 16'(base);
    cfg_size = 2'(size); sts_rd = rd;
    #2;
    b = (addr >> 16) & 255; g = b >> 5; off = addr & 65535;
    en = 0; ms = 0; ea = 0;
    if (!req) t = "R4";
    else if (b == 0) begin
      en = 1; t = "R5"; ea = (16'hE000 + (off % 8192)) % 65536;
    end else if (bank_m[g] == b && b != 255) begin
      en = 1; t = "R2"; ea = (base_m[g] + (off & ((1024 << size_m[g]) - 1))) % 65536;
    end else begin
      ms = 1; t = "R4";
    end
    if (tag != "") t = tag;
    chk(t, "sram_en", int'(sram_en), en);
    chk(t, "cpu_miss", int'(cpu_miss), ms);
    if (en == 1) begin
      chk(t, "sram_addr", int'(sram_addr), ea);
      chk(t, "cpu_rdata", int'(cpu_rdata), int'({16'hC0DE, 16'(ea)}));
    end
    if (ms == 1) chk(t, "cpu_rdata", int'(cpu_rdata), int'(32'h0BAD_F00D));
    t = (tag != "") ? tag : "R8";
    chk(t, "sts_miss", int'(sts_miss), flag_m);
    if (flag_m == 1) begin
      chk(t, "sts_bank", int'(sts_bank), sbank_m);
      chk(t, "sts_grp", int'(sts_grp), sgrp_m);
    end
    if (bwe) bank_m[grp] = bnk;
    if (rwe) begin base_m[grp] = base; size_m[grp] = size; end
    if (ms == 1) begin flag_m = 1; sbank_m = b; sgrp_m = g; end
    else if (rd) flag_m = 0;
  endtask

  task automatic rdx(string tag, int addr);
    step(tag, 1'b1, addr, 1'b0, 1'b0, 0, 0, 0, 0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_req = 0; cpu_addr = 0; bank_we = 0; region_we = 0;
    cfg_grp = 0; cfg_bank = 0; cfg_base = 0; cfg_size = 0; sts_rd = 0;
    for (int i = 0; i < 8; i++) begin bank_m[i] = 255; base_m[i] = 0; size_m[i] = 0; end
    flag_m = 0; sbank_m = 0; sgrp_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: reset state, everything banked misses
    step("R6", 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    rdx("R6", 24'h20_0010);
    rdx("R5", 24'h00_1234);
    rdx("R5", 24'h00_FFFF);
    rdx("R6", 24'hFF_0000);
    // R7: same-cycle write is not yet seen, next cycle is
    step("R7", 1'b1, 24'h25_0040, 1, 0, 1, 8'h25, 0, 0, 0);
    rdx("R7", 24'h25_0040);
    // R10: region write applies one cycle later
    step("R10", 1'b1, 24'h25_0040, 0, 1, 1, 0, 16'h4000, 0, 0);
    rdx("R10", 24'h25_0040);
    // R3: offset bits above the page are dropped
    rdx("R3", 24'h25_07FF);
    rdx("R3", 24'h25_ABCD);
    step("R3", 1'b0, 0, 0, 1, 1, 0, 16'h4000, 3, 0);
    rdx("R3", 24'h25_ABCD);
    step("R3", 1'b0, 0, 0, 1, 1, 0, 16'hF000, 2, 0);
    rdx("R3", 24'h25_3FFF);
    // R1: group comes from bank bits 7:5
    rdx("R1", 24'h3F_0000);
    step("R1", 1'b0, 0, 1, 0, 2, 8'h25, 0, 0, 0);
    rdx("R1", 24'h25_0004);
    rdx("R1", 24'h45_0004);
    step("R1", 1'b0, 0, 1, 0, 2, 8'h45, 0, 0, 0);
    rdx("R1", 24'h45_0004);
    // R5: resident bank ignores the group 0 register
    step("R5", 1'b0, 0, 1, 0, 0, 8'h00, 0, 0, 0);
    rdx("R5", 24'h00_2345);
    // R6: writing the reserved value never makes 0xFF hit
    step("R6", 1'b0, 0, 1, 0, 7, 8'hFF, 0, 0, 0);
    rdx("R6", 24'hFF_0010);
    // R8 / R9: sticky flag, clear on read, miss beats clear
    rdx("R8", 24'h61_0000);
    step("R8", 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1'b0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R9", 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1'b1, 24'h82_0000, 0, 0, 0, 0, 0, 0, 1);
    step("R9", 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      int pick, bk, a, g2;
      pick = $urandom_range(0, 7);
      case (pick)
        0: bk = 0;
        1: bk = 8'h25;
        2: bk = 8'h21;
        3: bk = 8'h45;
        4: bk = 8'h60;
        5: bk = 8'hFF;
        default: bk = $urandom_range(0, 255);
      endcase
      a = (bk << 16) | $urandom_range(0, 65535);
      g2 = $urandom_range(0, 7);
      step("", $urandom_range(0, 3) != 0, a,
           $urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0, g2,
           ($urandom_range(0, 1) == 0) ? ((g2 << 5) | $urandom_range(0, 31)) : bk,
           $urandom_range(0, 65535), $urandom_range(0, 3),
           $urandom_range(0, 4) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule